// File: doc/BRIEF.md
# Instruction-Pointer Stride Prefetch Engine

This block watches the demand loads of a data cache. Each access carries the instruction pointer of the load, a cache line address and hit and store flags. A small fully associative table keeps one training record per load instruction. Each record holds the line of the last miss, the last line delta, a three-level confidence state and a recency age. Only misses train a record. Hits and stores pass by and leave the table as it was.

When one instruction misses on lines X, X+d and X+2d, with the same non-zero d and |d| no larger than a stride limit (32 lines by default), the engine asks for exactly one line, X+3d. Every later miss that keeps the same stride asks for one more line: the miss line plus d. Requests leave through a one-entry valid/ready holding register. A request that finds the register full and not being drained is discarded, so training never stalls. Line arithmetic wraps modulo the line-address width.

Top module: `ip_stride_pf`

## Requirements
- R1: Each instruction pointer trains its own record. Misses from other instruction pointers interleaved between its misses do not disturb its stride detection.
- R2: Up to NUM_ENTRIES (default 12) distinct instruction pointers are tracked at the same time without loss of training.
- R3: An access with acc_hit=1 or acc_store=1 changes no training or recency state. The next miss of that instruction behaves as if the access never happened.
- R4: A line delta whose magnitude exceeds MAX_STRIDE (default 32) restarts the record, and the current miss becomes its first miss. Deltas of exactly +32 or -32 qualify.
- R5: The third consecutive miss of an instruction at X, X+d, X+2d (with d non-zero and in range) makes pf_valid=1 on the next clock, with pf_line = X+3d.
- R6: A stride of zero never produces a prefetch.
- R7: A qualifying delta that differs from the recorded stride replaces the stride without a prefetch. The next miss at the new stride then prefetches.
- R8: Once all entries are in use, a new instruction pointer takes the entry whose last training miss is the oldest. The instructions that remain keep their training.
- R9: While pf_valid=1 and pf_ready=0, pf_line holds. A request that arrives then is discarded. A request that arrives while the register drains (pf_valid=1, pf_ready=1) replaces the request being drained.
- R10: Synchronous active-low reset empties the table and clears pf_valid.
- R11: In the steady state, every further miss at the recorded stride requests that miss line plus the stride, one request per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_ip | input | IP_W | Instruction pointer of the access |
| acc_line | input | LINE_W | Line address of the access |
| acc_hit | input | 1 | The access hit in the cache |
| acc_store | input | 1 | The access is a store |
| pf_valid | output | 1 | A prefetch request is held |
| pf_ready | input | 1 | The consumer takes the held request |
| pf_line | output | LINE_W | Line address of the held request |

## Verification
The bench goes after several corner cases, and each one shows a particular wrong design:
- The stride limit at exactly ±32 against 33. A design with the bound off by one would prefetch after large jumps or miss legal ones.
- Hits and stores placed inside a training run. A design that trains on them would shift its stride or lose a prefetch.
- A stride change in the middle of a run. A design that reports the new stride at once would prefetch too early.
- A run of zero deltas, which would give a prefetch of the same line.
- The thirteenth instruction pointer, which must evict the least recently trained one. A design that evicts by index or by insertion order would either keep the wrong record or drop a record that is still training.
- A blocked consumer, which must not see its held line overwritten.

// File: rtl/ipsp_pkg.sv
package ipsp_pkg;

  typedef enum logic [1:0] {
    TR_INIT   = 2'd0,
    TR_TRANS  = 2'd1,
    TR_STEADY = 2'd2
  } train_st_e;

  typedef struct packed {
    train_st_e nxt;
    logic      load_stride;
    logic      fire;
  } train_step_t;

  // Confidence update for one training miss.
  function automatic train_step_t train_step(train_st_e cur, logic in_range,
                                             logic same, logic nonzero);
    train_step_t r;
    r.nxt         = TR_INIT;
    r.load_stride = 1'b0;
    r.fire        = 1'b0;
    if (in_range) begin
      case (cur)
        TR_INIT: begin
          r.nxt         = TR_TRANS;
          r.load_stride = 1'b1;
        end
        TR_TRANS: begin
          if (same && nonzero) begin
            r.nxt  = TR_STEADY;
            r.fire = 1'b1;
          end else begin
            r.nxt         = TR_TRANS;
            r.load_stride = 1'b1;
          end
        end
        TR_STEADY: begin
          if (same) begin
            r.nxt  = TR_STEADY;
            r.fire = 1'b1;
          end else begin
            r.nxt         = TR_TRANS;
            r.load_stride = 1'b1;
          end
        end
        default: r.nxt = TR_INIT;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ipsp_lru.sv
module ipsp_lru #(
  parameter int N     = 12,
  parameter int IDX_W = $clog2(N),
  parameter int AGE_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch,
  input  logic [IDX_W-1:0]           touch_idx,
  output logic [N-1:0][AGE_W-1:0]    ages_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(N - 1);

  logic [AGE_W-1:0] touched_age;
  assign touched_age = ages_o[touch_idx];

  for (genvar i = 0; i < N; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ages_o[i] <= AGE_MAX;
      end else if (touch) begin
        if (touch_idx == IDX_W'(i))
          ages_o[i] <= '0;
        else if (ages_o[i] < touched_age)
          ages_o[i] <= ages_o[i] + 1'b1;
      end
    end
  end

  AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> ages_o[$past(touch_idx)] == '0); // R8

endmodule

// File: rtl/ipsp_table.sv
module ipsp_table #(
  parameter int N      = 12,
  parameter int IP_W   = 16,
  parameter int LINE_W = 26,
  parameter int STR_W  = 7,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [IP_W-1:0]                   lookup_ip,
  input  logic                              wr_en,
  input  logic                              wr_alloc,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [IP_W-1:0]                   wr_tag,
  input  logic [LINE_W-1:0]                 wr_line,
  input  logic [STR_W-1:0]                  wr_stride,
  input  ipsp_pkg::train_st_e               wr_state,
  output logic [N-1:0]                      hit_vec_o,
  output logic [N-1:0]                      valid_o,
  output logic [N-1:0][LINE_W-1:0]          line_o,
  output logic [N-1:0][STR_W-1:0]           stride_o,
  output ipsp_pkg::train_st_e [N-1:0]       state_o
);

  logic [N-1:0][IP_W-1:0] tag_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[i]  <= 1'b0;
        tag_q[i]    <= '0;
        line_o[i]   <= '0;
        stride_o[i] <= '0;
        state_o[i]  <= ipsp_pkg::TR_INIT;
      end else if (sel) begin
        valid_o[i]  <= 1'b1;
        if (wr_alloc) tag_q[i] <= wr_tag;
        line_o[i]   <= wr_line;
        stride_o[i] <= wr_stride;
        state_o[i]  <= wr_state;
      end
    end

    assign hit_vec_o[i] = valid_o[i] && (tag_q[i] == lookup_ip);
  end

endmodule

// File: rtl/ipsp_pf_out.sv
module ipsp_pf_out #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LINE_W-1:0] req_line,
  input  logic              ready,
  output logic              valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic              drop_o
);

  logic accept;
  assign accept = req && (!valid_o || ready);
  assign drop_o = req && valid_o && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      line_o  <= '0;
    end else if (accept) begin
      valid_o <= 1'b1;
      line_o  <= req_line;
    end else if (ready) begin
      valid_o <= 1'b0;
    end
  end

  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready |=> valid_o && $stable(line_o)); // R9

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> line_o != $past(req_line) || line_o == $past(line_o)); // R9

endmodule

// File: rtl/ip_stride_pf.sv
module ip_stride_pf #(
  parameter int NUM_ENTRIES = 12,
  parameter int IP_W        = 16,
  parameter int LINE_W      = 26,
  parameter int MAX_STRIDE  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [IP_W-1:0]   acc_ip,
  input  logic [LINE_W-1:0] acc_line,
  input  logic              acc_hit,
  input  logic              acc_store,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);
  import ipsp_pkg::*;

  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int AGE_W = $clog2(NUM_ENTRIES);
  localparam int STR_W = $clog2(MAX_STRIDE) + 2;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(NUM_ENTRIES - 1);

  // Named internal events
  logic                                  train_ev;
  logic                                  hit_any;
  logic [IDX_W-1:0]                      hit_idx;
  logic [IDX_W-1:0]                      victim_idx;
  logic [IDX_W-1:0]                      sel_idx;
  logic                                  pf_req;
  logic                                  pf_drop;
  logic [LINE_W-1:0]                     pf_req_line;

  logic [NUM_ENTRIES-1:0]                hit_vec;
  logic [NUM_ENTRIES-1:0]                ent_valid;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0]    ent_line;
  logic [NUM_ENTRIES-1:0][STR_W-1:0]     ent_stride;
  train_st_e [NUM_ENTRIES-1:0]           ent_state;
  logic [NUM_ENTRIES-1:0][AGE_W-1:0]     ages;

  logic signed [LINE_W:0]                delta;
  logic [STR_W-1:0]                      delta_s;
  logic                                  in_range;
  logic                                  same_stride;
  logic                                  nonzero;
  train_step_t                           step;

  logic [STR_W-1:0]                      wr_stride;
  train_st_e                             wr_state;

  assign train_ev = acc_valid && !acc_hit && !acc_store;
  assign hit_any  = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  // Victim: lowest free entry, else lowest entry at the oldest age
  always_comb begin
    logic found_free;
    found_free = 1'b0;
    victim_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (ages[i] == AGE_MAX) victim_idx = IDX_W'(i);
    for (int i = NUM_ENTRIES - 1; i >= 0; i--)
      if (!ent_valid[i]) begin
        victim_idx = IDX_W'(i);
        found_free = 1'b1;
      end
  end

  assign sel_idx = hit_any ? hit_idx : victim_idx;

  // Delta arithmetic
  assign delta       = $signed({1'b0, acc_line}) - $signed({1'b0, ent_line[hit_idx]});
  assign in_range    = (delta <= MAX_STRIDE) && (delta >= -MAX_STRIDE);
  assign delta_s     = delta[STR_W-1:0];
  assign same_stride = (delta_s == ent_stride[hit_idx]);
  assign nonzero     = (delta != '0);
  assign step        = train_step(ent_state[hit_idx], in_range, same_stride, nonzero);

  always_comb begin
    if (hit_any) begin
      wr_state  = step.nxt;
      wr_stride = step.load_stride ? delta_s : ent_stride[hit_idx];
    end else begin
      wr_state  = TR_INIT;
      wr_stride = '0;
    end
  end

  assign pf_req      = train_ev && hit_any && step.fire;
  assign pf_req_line = acc_line + {{(LINE_W - STR_W){delta_s[STR_W-1]}}, delta_s};

  ipsp_table #(
    .N(NUM_ENTRIES), .IP_W(IP_W), .LINE_W(LINE_W), .STR_W(STR_W), .IDX_W(IDX_W)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookup_ip (acc_ip),
    .wr_en     (train_ev),
    .wr_alloc  (!hit_any),
    .wr_idx    (sel_idx),
    .wr_tag    (acc_ip),
    .wr_line   (acc_line),
    .wr_stride (wr_stride),
    .wr_state  (wr_state),
    .hit_vec_o (hit_vec),
    .valid_o   (ent_valid),
    .line_o    (ent_line),
    .stride_o  (ent_stride),
    .state_o   (ent_state)
  );

  ipsp_lru #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .AGE_W(AGE_W)) i_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (train_ev),
    .touch_idx (sel_idx),
    .ages_o    (ages)
  );

  ipsp_pf_out #(.LINE_W(LINE_W)) i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (pf_req),
    .req_line (pf_req_line),
    .ready    (pf_ready),
    .valid_o  (pf_valid),
    .line_o   (pf_line),
    .drop_o   (pf_drop)
  );

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1

  AST_QUIET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_hit || acc_store) |=> $stable(ent_line) && $stable(ent_state) && $stable(ages)); // R3

  AST_FIRE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> nonzero && in_range); // R6

  AST_ALLOC_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    train_ev && !hit_any |-> !ent_valid[victim_idx] || ages[victim_idx] == AGE_MAX); // R8

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pf_drop |-> pf_valid && !pf_ready); // R9

endmodule

// File: tb/test_ip_stride_pf.sv
`timescale 1ns/1ps
module test_ip_stride_pf;
  localparam int  IP_W   = 16;
  localparam int  LINE_W = 26;
  localparam longint MASK = (64'd1 << LINE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic [IP_W-1:0]   acc_ip = '0;
  logic [LINE_W-1:0] acc_line = '0;
  logic              acc_hit = 1'b0;
  logic              acc_store = 1'b0;
  logic              pf_ready = 1'b1;
  logic              pf_valid;
  logic [LINE_W-1:0] pf_line;

  always #5 clk = ~clk;

  ip_stride_pf i_ip_stride_pf (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ip(acc_ip),
    .acc_line(acc_line), .acc_hit(acc_hit), .acc_store(acc_store),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R10";

  // Behavioural reference model
  longint m_last[int];
  int     m_str[int];
  int     m_st[int];
  int     m_rec[$];
  bit     m_v = 0;
  longint m_line = 0;

  task automatic model_miss(int ip, longint line, output bit req, output longint rline);
    int d;
    req = 0; rline = 0;
    if (m_last.exists(ip)) begin
      d = int'(line - m_last[ip]);
      if (d > 32 || d < -32) m_st[ip] = 0;
      else if (m_st[ip] == 0) begin m_str[ip] = d; m_st[ip] = 1; end
      else if (m_st[ip] == 1) begin
        if (d == m_str[ip] && d != 0) begin m_st[ip] = 2; req = 1; end
        else m_str[ip] = d;
      end else begin
        if (d == m_str[ip]) req = 1;
        else begin m_str[ip] = d; m_st[ip] = 1; end
      end
      m_last[ip] = line;
      foreach (m_rec[k]) if (m_rec[k] == ip) begin m_rec.delete(k); break; end
      m_rec.push_front(ip);
      if (req) rline = (line + d) & MASK;
    end else begin
      if (m_rec.size() == 12) begin
        int old;
        old = m_rec.pop_back();
        m_last.delete(old); m_str.delete(old); m_st.delete(old);
      end
      m_last[ip] = line; m_str[ip] = 0; m_st[ip] = 0;
      m_rec.push_front(ip);
    end
  endtask

  always @(posedge clk) begin
    bit req; longint rl;
    if (!rst_n) begin
      m_last.delete(); m_str.delete(); m_st.delete(); m_rec.delete(); m_v = 0;
    end else begin
      req = 0; rl = 0;
      if (acc_valid && !acc_hit && !acc_store) model_miss(int'(acc_ip), longint'(acc_line), req, rl);
      if (req && (!m_v || pf_ready)) begin m_v = 1; m_line = rl; end
      else if (pf_ready) m_v = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (pf_valid !== m_v || (m_v && longint'(pf_line) != m_line)) begin
        n_fail++;
        $display("FAIL %s model compare: valid=%0b line=%0d expected valid=%0b line=%0d",
                 cur_req, pf_valid, pf_line, m_v, m_line);
      end
    end
  end

  task automatic chk_pf(bit ev, longint el, string tag);
    n_tests++;
    if (pf_valid !== ev || (ev && longint'(pf_line) != el)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b line=%0d expected valid=%0b line=%0d",
               tag, pf_valid, pf_line, ev, el);
    end
  endtask

  task automatic acc(int ip, longint line, bit hit = 0, bit st = 0);
    acc_valid = 1; acc_ip = IP_W'(ip); acc_line = LINE_W'(line);
    acc_hit = hit; acc_store = st;
    @(negedge clk);
    acc_valid = 0; acc_hit = 0; acc_store = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_pf(0, 0, "R10 reset");

    cur_req = "R5";
    acc(5, 1000); chk_pf(0, 0, "R5 first miss");
    acc(5, 1004); chk_pf(0, 0, "R5 second miss");
    acc(5, 1008); chk_pf(1, 1012, "R5 third miss");
    cur_req = "R11";
    acc(5, 1012); chk_pf(1, 1016, "R11 steady");
    idle(1);      chk_pf(0, 0, "R11 drained");

    cur_req = "R3";
    acc(5, 5000, 1, 0); chk_pf(0, 0, "R3 hit");
    acc(5, 7000, 0, 1); chk_pf(0, 0, "R3 store");
    acc(5, 1016); chk_pf(1, 1020, "R3 training kept");
    idle(1);

    cur_req = "R6";
    acc(6, 200); acc(6, 200); acc(6, 200); acc(6, 200);
    chk_pf(0, 0, "R6 zero stride");

    cur_req = "R4";
    acc(7, 3000); acc(7, 3033); acc(7, 3066); acc(7, 3099);
    chk_pf(0, 0, "R4 delta 33");
    acc(8, 4000); acc(8, 3968); acc(8, 3936);
    chk_pf(1, 3904, "R4 delta -32");
    idle(1);
    acc(12, 100); acc(12, 200); acc(12, 232); acc(12, 264);
    chk_pf(1, 296, "R4 restart after jump");
    idle(1);

    cur_req = "R7";
    acc(9, 100); acc(9, 102); acc(9, 104); chk_pf(1, 106, "R7 first run");
    acc(9, 107); chk_pf(0, 0, "R7 mismatch");
    acc(9, 110); chk_pf(1, 113, "R7 new stride");
    idle(1);

    cur_req = "R1";
    acc(10, 500); acc(11, 900); acc(10, 510); acc(11, 890);
    acc(10, 520); chk_pf(1, 530, "R1 ip10");
    acc(11, 880); chk_pf(1, 870, "R1 ip11");
    idle(1);

    cur_req = "R2";
    for (int k = 20; k < 32; k++) acc(k, k * 100);
    for (int k = 20; k < 32; k++) acc(k, k * 100 + 1);
    acc(20, 2002); chk_pf(1, 2003, "R2 twelve tracked");
    cur_req = "R8";
    acc(40, 9000);
    acc(21, 2102); chk_pf(0, 0, "R8 LRU evicted");
    acc(23, 2302); chk_pf(1, 2303, "R8 survivor kept");
    idle(1);

    cur_req = "R9";
    pf_ready = 0;
    acc(50, 0); acc(50, 8); acc(50, 16); chk_pf(1, 24, "R9 held");
    acc(50, 24); chk_pf(1, 24, "R9 drop while full");
    idle(2);     chk_pf(1, 24, "R9 still held");
    pf_ready = 1;
    idle(1);     chk_pf(0, 0, "R9 consumed");
    acc(50, 32); chk_pf(1, 40, "R9 training continued");
    idle(1);

    cur_req = "R5";
    acc(60, MASK - 2); acc(60, MASK - 1); acc(60, MASK);
    chk_pf(1, 0, "R5 wrap");
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule